// File: doc/BRIEF.md
# Presence-Detect Configuration EEPROM Target

This block sits on a memory module and answers a two-wire serial bus (SCL clock, open-drain SDA data) as a 256-byte configuration EEPROM. The host reads it during boot to learn how the module is organised: device type, row and column address widths, bank counts, supported burst lengths and CAS latencies, and timing values. It is byte-addressed through an internal pointer. The host sets the pointer with a one-byte word address in a write transfer, then reads one or many bytes.

The lower half of the space is a fixed, read-only descriptor. It ends in a checksum byte at index 63, which is derived from the preceding 63 bytes, and an identification field that starts at index 64. The upper half is free for the system's own use and accepts single or sequential byte writes, unless the write-protect input is high. The seven-bit bus address is the device-class prefix 1010b followed by three strap inputs.

The bus lines are sampled by a free-running system clock through synchronisers. The SDA output enable changes only in response to a detected SCL falling edge, a start condition or a stop condition.

Top module: `spd_eeprom_slave`

## Requirements
- R1: After reset the SDA enable is low, the byte pointer is 0 (a first current-address read returns 0x80) and every upper-half byte reads 0xFF.
- R2: A start followed by address byte {1010b, strap[2:0], rw} (rw = 0 write, 1 read) is acknowledged by SDA held low during the ninth SCL clock, and a changed strap value moves the address to match.
- R3: Any other address byte gets no acknowledge, and SDA is not driven again until the next start.
- R4: A write transfer carrying one word-address byte, then a repeated start and a read, returns the byte at that address (random read).
- R5: The pointer advances by one after every byte read or written and wraps from 255 to 0.
- R6: Descriptor bytes read as: [0]=0x80, [1]=0x08, [2]=0x07, [3]=0x0D, [4]=0x09, [5]=0x02, [9]=0x75, [10]=0x75, [16]=0x0E, [17]=0x04, [18]=0x0C, [63]=0xA7 and equal to the low 8 bits of the sum of bytes 0..62, [64]..[66]=0x7F.
- R7: A data byte written to an address of 128 or more while write-protect is low is acknowledged and stored.
- R8: A data byte written to an address below 128 is acknowledged and leaves the byte unchanged.
- R9: A data byte written while write-protect is high is acknowledged and leaves the byte unchanged.
- R10: A master NACK after a read byte ends the transfer; the block releases SDA and drives nothing until the next start.
- R11: A stop condition releases SDA, and the SDA enable changes only after an SCL fall, a start or a stop.
- R12: In a sequential write the pointer keeps advancing, so each data byte lands at the next address and a later current-address read continues from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Resolved level of the serial data line |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| strap_i | input | 3 | Board straps, low three bits of the bus address |
| wp_i | input | 1 | Write-protect; high blocks all stores |

## Verification
The checker follows every cycle. It confirms that SDA is released while idle and after a stop, and that the SDA enable moves only after a bus event. It also confirms that the pointer either steps by one or is loaded from a word-address byte, and that a store happens only at the end of a received data byte. Only the bench scenarios can show the data-level behaviour: the descriptor contents and checksum, the acknowledge or silence for each address, the wrap of a long sequential read, and that blocked writes leave the old contents in place.

// File: rtl/spd_pkg.sv
package spd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } spd_state_e;

    // Fixed descriptor contents, index 0..127; index 63 is filled from the sum.
    function automatic logic [7:0] desc_raw(input logic [7:0] idx);
        logic [7:0] v;
        case (idx)
            8'd0:  v = 8'h80;
            8'd1:  v = 8'h08;
            8'd2:  v = 8'h07;
            8'd3:  v = 8'h0D;
            8'd4:  v = 8'h09;
            8'd5:  v = 8'h02;
            8'd6:  v = 8'h40;
            8'd8:  v = 8'h04;
            8'd9:  v = 8'h75;
            8'd10: v = 8'h75;
            8'd12: v = 8'h82;
            8'd13: v = 8'h10;
            8'd15: v = 8'h01;
            8'd16: v = 8'h0E;
            8'd17: v = 8'h04;
            8'd18: v = 8'h0C;
            8'd19: v = 8'h01;
            8'd20: v = 8'h02;
            8'd21: v = 8'h20;
            8'd23: v = 8'hA0;
            8'd24: v = 8'h75;
            8'd27: v = 8'h50;
            8'd28: v = 8'h3C;
            8'd29: v = 8'h50;
            8'd30: v = 8'h2D;
            8'd31: v = 8'h20;
            8'd32: v = 8'h90;
            8'd33: v = 8'h90;
            8'd34: v = 8'h50;
            8'd35: v = 8'h50;
            8'd64: v = 8'h7F;
            8'd65: v = 8'h7F;
            8'd66: v = 8'h7F;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    localparam int unsigned CSUM_IDX = 63;

    function automatic logic [7:0] desc_sum();
        logic [7:0] s;
        s = 8'h00;
        for (int i = 0; i < CSUM_IDX; i++) begin
            s = s + desc_raw(8'(i));
        end
        return s;
    endfunction

    localparam logic [7:0] DESC_CSUM = desc_sum();

    function automatic logic [7:0] desc_byte(input logic [7:0] idx);
        return (idx == 8'(CSUM_IDX)) ? DESC_CSUM : desc_raw(idx);
    endfunction

endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] scl_sync;
        logic [STAGES-1:0] sda_sync;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.scl_sync = {q.scl_sync[LAST-1:0], scl_i};
        d.sda_sync = {q.sda_sync[LAST-1:0], sda_i};
        d.scl_prev = q.scl_sync[LAST];
        d.sda_prev = q.sda_sync[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    logic scl_s, sda_s;
    assign scl_s      = q.scl_sync[LAST];
    assign sda_s      = q.sda_sync[LAST];
    assign sda_o      = sda_s;
    assign scl_rise_o = scl_s & ~q.scl_prev;
    assign scl_fall_o = ~scl_s & q.scl_prev;
    assign start_o    = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
    assign stop_o     = scl_s & q.scl_prev & ~q.sda_prev & sda_s;
endmodule

// File: rtl/spd_store.sv
module spd_store #(
    parameter int         ADDR_W = 8,
    parameter logic [7:0] ERASED = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-2:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    import spd_pkg::*;

    localparam int HALF = 2 ** (ADDR_W - 1);

    logic [7:0] mem_q [HALF];
    logic [7:0] mem_d [HALF];

    always_comb begin
        for (int i = 0; i < HALF; i++) mem_d[i] = mem_q[i];
        if (wr_en) mem_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < HALF; i++) mem_q[i] <= ERASED;
        end else begin
            for (int i = 0; i < HALF; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = rd_addr[ADDR_W-1] ? mem_q[rd_addr[ADDR_W-2:0]]
                                       : desc_byte(8'(rd_addr));
endmodule

// File: rtl/spd_eeprom_slave.sv
module spd_eeprom_slave #(
    parameter int         ADDR_W   = 8,
    parameter int         STRAP_W  = 3,
    parameter logic [3:0] DEV_TYPE = 4'b1010,
    parameter int         STAGES   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               wp_i
);
    import spd_pkg::*;

    localparam int         TOP_BIT  = ADDR_W - 1;
    localparam logic [3:0] BITS_END = 4'd8;

    typedef struct packed {
        spd_state_e        st;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [ADDR_W-1:0] ptr;
        logic              nack;
        logic              oe;
        logic              we;
        logic [ADDR_W-2:0] waddr;
        logic [7:0]        wdata;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{st: ST_IDLE, default: '0};

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] rd_data;
    ctl_t q, d;

    spd_line_sync #(.STAGES(STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    spd_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (q.we),
        .wr_addr (q.waddr),
        .wr_data (q.wdata),
        .rd_addr (q.ptr),
        .rd_data (rd_data)
    );

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_WORD, ST_WDATA: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == BITS_END) begin
                        if (q.st == ST_ADDR) begin
                            if (q.sh[7:1] == {DEV_TYPE, strap_i}) begin
                                d.st = ST_ADDR_ACK;
                                d.oe = 1'b1;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else if (q.st == ST_WORD) begin
                            d.ptr = ADDR_W'(q.sh);
                            d.st  = ST_WORD_ACK;
                            d.oe  = 1'b1;
                        end else begin
                            d.st  = ST_WDATA_ACK;
                            d.oe  = 1'b1;
                            d.ptr = q.ptr + 1'b1;
                            if (q.ptr[TOP_BIT] && !wp_i) begin
                                d.we    = 1'b1;
                                d.waddr = q.ptr[ADDR_W-2:0];
                                d.wdata = q.sh;
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.sh[0]) begin
                            d.st  = ST_RDATA;
                            d.sh  = rd_data;
                            d.ptr = q.ptr + 1'b1;
                            d.oe  = ~rd_data[7];
                        end else begin
                            d.st = ST_WORD;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_WORD_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        d.st  = ST_WDATA;
                        d.cnt = '0;
                        d.oe  = 1'b0;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == BITS_END) begin
                            d.st = ST_RACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.nack = sda_s;
                    end else if (scl_fall) begin
                        d.cnt = '0;
                        if (q.nack) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.st  = ST_RDATA;
                            d.sh  = rd_data;
                            d.ptr = q.ptr + 1'b1;
                            d.oe  = ~rd_data[7];
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RESET;
        else        q <= d;
    end

    assign sda_oe_o = q.oe;
endmodule

// File: rtl/spd_eeprom_slave_chk.sv
module spd_eeprom_slave_chk #(
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sda_oe,
    input logic                scl_fall,
    input logic                start_det,
    input logic                stop_det,
    input spd_pkg::spd_state_e st,
    input logic [ADDR_W-1:0]   ptr,
    input logic                we
);
    import spd_pkg::*;

    // R3
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);

    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R11
    oe_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(scl_fall) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> ((ptr == $past(ptr) + 1'b1) || $past(st == ST_WORD)));

    // R7
    store_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> $past(st == ST_WDATA));

    // R12
    store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we);
endmodule

bind spd_eeprom_slave spd_eeprom_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe_o),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .st        (q.st),
    .ptr       (q.ptr),
    .we        (q.we)
);

// File: tb/test_spd_eeprom_slave.sv
module test_spd_eeprom_slave;
    localparam int Q = 8;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic [2:0] strap = 3'b101;
    logic wp = 1'b0;
    logic dut_oe;
    logic sda_bus;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] img [256];
    logic [7:0] up_exp [128];

    always #2 clk = ~clk;

    assign sda_bus = ~(m_sda_low | dut_oe);

    spd_eeprom_slave i_spd_eeprom_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .sda_oe_o (dut_oe),
        .strap_i  (strap),
        .wp_i     (wp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; tick(Q);
        m_scl = 1'b1;     tick(Q);
        m_sda_low = 1'b1; tick(Q);
        m_scl = 1'b0;     tick(Q);
    endtask

    task automatic bus_stop();
        m_scl = 1'b0; m_sda_low = 1'b1; tick(Q);
        m_scl = 1'b1;     tick(Q);
        m_sda_low = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = ~b[i]; tick(Q);
            m_scl = 1'b1;      tick(2 * Q);
            m_scl = 1'b0;      tick(Q);
        end
        m_sda_low = 1'b0; tick(Q);
        m_scl = 1'b1;     tick(Q);
        ack = ~sda_bus;   tick(Q);
        m_scl = 1'b0;     tick(Q);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = 1'b0; tick(Q);
            m_scl = 1'b1;     tick(Q);
            b[i] = sda_bus;   tick(Q);
            m_scl = 1'b0;     tick(Q);
        end
        m_sda_low = ~nack; tick(Q);
        m_scl = 1'b1;      tick(2 * Q);
        m_scl = 1'b0;      tick(Q);
        m_sda_low = 1'b0;
    endtask

    function automatic logic [7:0] dev_addr(input logic [2:0] s, input logic rd);
        return {4'b1010, s, rd};
    endfunction

    // Sets the pointer and leaves the bus after the word-address acknowledge.
    task automatic set_ptr(input logic [7:0] a, input string req);
        logic ack;
        bus_start();
        send_byte(dev_addr(strap, 1'b0), ack);
        chk({req, " address ack"}, ack, 1'b1);
        send_byte(a, ack);
        chk({req, " word ack"}, ack, 1'b1);
    endtask

    function automatic logic [7:0] expect_at(input logic [7:0] a);
        return a[7] ? up_exp[a[6:0]] : img[a];
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] b;
        logic [7:0] sum;
        logic [7:0] a;

        for (int i = 0; i < 128; i++) up_exp[i] = 8'hFF;
        tick(5);
        chk("R1 oe in reset", dut_oe, 1'b0);
        rst_n = 1'b1;
        tick(5);
        chk("R1 oe after reset", dut_oe, 1'b0);

        // R1: first current-address read starts at pointer 0
        bus_start();
        send_byte(dev_addr(strap, 1'b1), ack);
        chk("R2 read address ack", ack, 1'b1);
        recv_byte(1'b1, b);
        chk("R1 pointer reset read", b, 8'h80);
        chk("R10 release after nack", dut_oe, 1'b0);
        tick(3 * Q);
        chk("R10 silent after nack", dut_oe, 1'b0);
        bus_stop();

        // R3: foreign address, then a further byte must see no drive
        bus_start();
        send_byte(dev_addr(3'b000, 1'b0), ack);
        chk("R3 foreign address nack", ack, 1'b0);
        send_byte(8'h00, ack);
        chk("R3 no drive after mismatch", ack, 1'b0);
        bus_stop();
        chk("R11 released after stop", dut_oe, 1'b0);

        // Full sweep: 256 bytes plus one to show the wrap (R5)
        set_ptr(8'h00, "R4");
        bus_start();
        send_byte(dev_addr(strap, 1'b1), ack);
        chk("R4 repeated start ack", ack, 1'b1);
        for (int i = 0; i < 256; i++) begin
            recv_byte(1'b0, b);
            img[i] = b;
        end
        recv_byte(1'b1, b);
        chk("R5 wrap to byte 0", b, 8'h80);
        bus_stop();
        chk("R11 released after stop", dut_oe, 1'b0);

        chk("R6 byte 0", img[0], 8'h80);
        chk("R6 byte 1", img[1], 8'h08);
        chk("R6 byte 2", img[2], 8'h07);
        chk("R6 byte 3", img[3], 8'h0D);
        chk("R6 byte 4", img[4], 8'h09);
        chk("R6 byte 5", img[5], 8'h02);
        chk("R6 byte 9", img[9], 8'h75);
        chk("R6 byte 10", img[10], 8'h75);
        chk("R6 byte 16", img[16], 8'h0E);
        chk("R6 byte 17", img[17], 8'h04);
        chk("R6 byte 18", img[18], 8'h0C);
        chk("R6 byte 63", img[63], 8'hA7);
        for (int i = 64; i < 67; i++) chk("R6 id padding", img[i], 8'h7F);
        sum = 8'h00;
        for (int i = 0; i < 63; i++) sum = sum + img[i];
        chk("R6 checksum", img[63], sum);
        for (int i = 128; i < 256; i++) chk("R1 erased upper", img[i], 8'hFF);

        // R12/R7/R8: sequential write from 0xF0 across the wrap into the locked half
        set_ptr(8'hF0, "R12");
        for (int k = 0; k < 32; k++) begin
            a = 8'(8'hF0 + k);
            b = 8'((k * 37 + 5) & 8'hFF);
            send_byte(b, ack);
            if (a[7]) begin
                chk("R7 data ack", ack, 1'b1);
                up_exp[a[6:0]] = b;
            end else begin
                chk("R8 locked data ack", ack, 1'b1);
            end
        end
        bus_stop();

        set_ptr(8'hF0, "R4");
        bus_start();
        send_byte(dev_addr(strap, 1'b1), ack);
        for (int k = 0; k < 32; k++) begin
            a = 8'(8'hF0 + k);
            recv_byte(k == 31, b);
            if (a[7]) chk("R12 sequential store", b, expect_at(a));
            else      chk("R8 locked unchanged", b, expect_at(a));
        end
        bus_stop();

        // R9: write-protect blocks an upper-half store
        wp = 1'b1;
        set_ptr(8'h90, "R9");
        send_byte(8'h3C, ack);
        chk("R9 protected data ack", ack, 1'b1);
        bus_stop();
        wp = 1'b0;
        set_ptr(8'h90, "R9");
        bus_start();
        send_byte(dev_addr(strap, 1'b1), ack);
        recv_byte(1'b1, b);
        chk("R9 protected unchanged", b, expect_at(8'h90));
        bus_stop();

        // R7: same store with protection off
        set_ptr(8'h90, "R7");
        send_byte(8'h3C, ack);
        chk("R7 data ack", ack, 1'b1);
        bus_stop();
        up_exp[7'h10] = 8'h3C;

        // R12/R5: current-address read continues at 0x91
        bus_start();
        send_byte(dev_addr(strap, 1'b1), ack);
        recv_byte(1'b1, b);
        chk("R12 pointer after write", b, expect_at(8'h91));
        bus_stop();

        set_ptr(8'h90, "R7");
        bus_start();
        send_byte(dev_addr(strap, 1'b1), ack);
        recv_byte(1'b1, b);
        chk("R7 stored byte", b, 8'h3C);
        bus_stop();

        // R8: single write into the locked half
        set_ptr(8'h05, "R8");
        send_byte(8'hEE, ack);
        chk("R8 locked data ack", ack, 1'b1);
        bus_stop();
        set_ptr(8'h05, "R8");
        bus_start();
        send_byte(dev_addr(strap, 1'b1), ack);
        recv_byte(1'b1, b);
        chk("R8 locked unchanged", b, 8'h02);
        bus_stop();

        // R2/R3: strap change moves the address
        bus_start();
        send_byte(dev_addr(3'b101, 1'b0), ack);
        strap = 3'b010;
        bus_stop();
        tick(Q);
        bus_start();
        send_byte(dev_addr(3'b101, 1'b1), ack);
        chk("R3 old strap nack", ack, 1'b0);
        bus_stop();
        bus_start();
        send_byte(dev_addr(3'b010, 1'b1), ack);
        chk("R2 new strap ack", ack, 1'b1);
        recv_byte(1'b1, b);
        bus_stop();
        chk("R11 released after stop", dut_oe, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule